// File: doc/BRIEF.md
# Auxiliary External Interrupt Controller

This block handles two extra active-low external interrupt inputs, named source A and source B. One 8-bit control register configures both of them. Each source owns a nibble in that register: a type bit, a pending flag, an enable bit and a priority bit. The type bit selects one of two detection modes:

- **Edge mode:** a falling edge on the pin latches the flag. The flag stays set until a service acknowledge or software clears it.
- **Level mode:** the flag is a live view of the pin. It reads 1 while the synchronised pin is low.

The controller passes each pin through a synchroniser. It drives one request line and one priority-level line per source. It also gives a pre-selected winner to an external interrupt arbiter.

Software reaches the register in two ways. A byte port reads and writes the whole register at address 0xC0. A single-bit port sets or clears any one bit through its own bit address. The arbiter returns a one-cycle acknowledge per source when it services that source.

Top module: `eic_ctrl`

## Requirements
- R1: After synchronous reset the register reads 0x00, and no request or grant is active.
- R2: A byte write with `reg_addr` = 0xC0 loads the register. `reg_rdata` shows the register when `reg_addr` = 0xC0 and 0x00 at any other address. A write to any other address changes nothing. The bit map is: bit 7 B priority, bit 6 B enable, bit 5 B flag, bit 4 B type, bit 3 A priority, bit 2 A enable, bit 1 A flag, bit 0 A type.
- R3: A bit write with `bit_addr` = 0xC0 + n (n in 0..7) loads `bit_val` into bit n only.
- R4: With type = 1 (edge mode), a falling edge on a pin sets that source's flag on the third rising clock edge after the pin falls. The flag then stays set when the pin returns high.
- R5: In edge mode, an acknowledge clears the flag on the next edge. If a new edge is detected on the same clock, the set wins.
- R6: With type = 0 (level mode), the flag reads 1 exactly while the pin is low, delayed by two clocks. Acknowledges and software writes to the flag have no effect.
- R7: A request is active only while both the enable bit and the flag are 1. With enable = 0 the flag still sets, but no request is raised.
- R8: `irq_hi` of a source equals its priority bit while its request is active.
- R9: The grant goes to a high-priority request over a low one. On equal level, source A (id 0) wins over source B (id 1). `grant_valid` is 1 exactly when some request is active.
- R10: A pin held low in edge mode sets the flag only once. After an acknowledge, the flag stays clear until a new falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n | input | 2 | Asynchronous interrupt pins, active low (bit 0 = A, bit 1 = B) |
| reg_addr | input | 8 | Byte read/write address |
| reg_wr | input | 1 | Byte write strobe |
| reg_wdata | input | 8 | Byte write data |
| reg_rdata | output | 8 | Byte read data |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address (register base + bit index) |
| bit_val | input | 1 | Value for the addressed bit |
| ack | input | 2 | Service acknowledge per source |
| irq_req | output | 2 | Request per source |
| irq_hi | output | 2 | Priority level per source (1 = high) |
| grant_valid | output | 1 | Some request is active |
| grant_id | output | 1 | Selected source (0 = A, 1 = B) |
| grant_hi | output | 1 | Level of the selected source |

## Verification
Results become due at different delays after their stimulus:

| Result | Due after the stimulus |
|---|---|
| Register write, bit write or acknowledge | 1 clock edge |
| Level-mode flag | 2 clock edges after the pin moves |
| Edge-mode flag | 3 clock edges after the pin falls |
| Requests, levels and grant | Same cycle as the register state they derive from (combinational) |

The driver changes inputs just after a falling edge. It counts exactly those edges before it queues an expected value. The monitor compares that value a fraction of a nanosecond later, away from any rising edge.

The edge-flag check is also made one edge early, where it must still read clear. This pins the three-edge latency in both directions.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int SRC_N = 2;
    localparam int CFG_W = 4;
    localparam int REG_W = SRC_N * CFG_W;
    localparam int ID_W  = (SRC_N > 1) ? $clog2(SRC_N) : 1;

    // Bit position of each field inside one source nibble
    localparam int POS_TYP  = 0;
    localparam int POS_FLAG = 1;
    localparam int POS_EN   = 2;
    localparam int POS_PRI  = 3;

    typedef struct packed {
        logic pri;
        logic en;
        logic flag;
        logic typ;
    } src_cfg_t;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
        logic            hi;
    } grant_t;

    function automatic logic is_fall(input logic prev_lvl, input logic cur_lvl);
        return prev_lvl & ~cur_lvl;
    endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic lvl_n,
    output logic fall
);
    import eic_pkg::*;

    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], pin_n};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign lvl_n = sh_q[STAGES-1];
    assign fall  = is_fall(prev_q, sh_q[STAGES-1]);

endmodule

// File: rtl/eic_slot.sv
module eic_slot
    import eic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] wr_mask,
    input  logic [CFG_W-1:0] wr_val,
    input  logic             fall,
    input  logic             lvl_act,
    input  logic             ack,
    output src_cfg_t         cfg
);
    logic pri_q, en_q, typ_q, flag_e_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pri_q    <= 1'b0;
            en_q     <= 1'b0;
            typ_q    <= 1'b0;
            flag_e_q <= 1'b0;
        end else begin
            if (wr_mask[POS_PRI]) pri_q <= wr_val[POS_PRI];
            if (wr_mask[POS_EN])  en_q  <= wr_val[POS_EN];
            if (wr_mask[POS_TYP]) typ_q <= wr_val[POS_TYP];
            // Edge latch: detection beats acknowledge, acknowledge beats software
            if (!typ_q)                flag_e_q <= 1'b0;
            else if (fall)             flag_e_q <= 1'b1;
            else if (ack)              flag_e_q <= 1'b0;
            else if (wr_mask[POS_FLAG]) flag_e_q <= wr_val[POS_FLAG];
        end
    end

    always_comb begin
        cfg.pri  = pri_q;
        cfg.en   = en_q;
        cfg.typ  = typ_q;
        cfg.flag = typ_q ? flag_e_q : lvl_act;
    end

endmodule

// File: rtl/eic_sel.sv
module eic_sel
    import eic_pkg::*;
(
    input  logic [SRC_N-1:0] req,
    input  logic [SRC_N-1:0] hi,
    output grant_t           grant
);
    always_comb begin
        grant = '0;
        // Lowest index among all requests
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant.valid = 1'b1;
                grant.id    = ID_W'(i);
                grant.hi    = hi[i];
            end
        end
        // Lowest index among high-level requests overrides
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req[i] && hi[i]) begin
                grant.id = ID_W'(i);
                grant.hi = 1'b1;
            end
        end
    end

endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
    import eic_pkg::*;
#(
    parameter int                  ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]   REG_ADDR    = 8'hC0,
    parameter int                  SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SRC_N-1:0]       ext_n,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   reg_wr,
    input  logic [REG_W-1:0]       reg_wdata,
    output logic [REG_W-1:0]       reg_rdata,
    input  logic                   bit_wr,
    input  logic [ADDR_W-1:0]      bit_addr,
    input  logic                   bit_val,
    input  logic [SRC_N-1:0]       ack,
    output logic [SRC_N-1:0]       irq_req,
    output logic [SRC_N-1:0]       irq_hi,
    output logic                   grant_valid,
    output logic [ID_W-1:0]        grant_id,
    output logic                   grant_hi
);
    localparam int IDX_W = $clog2(REG_W);

    logic             byte_hit, bit_hit;
    logic [REG_W-1:0] wmask, wval, ctrl_q;
    grant_t           grant;

    assign byte_hit = reg_wr && (reg_addr == REG_ADDR);
    assign bit_hit  = bit_wr && (bit_addr[ADDR_W-1:IDX_W] == REG_ADDR[ADDR_W-1:IDX_W]);

    always_comb begin
        for (int k = 0; k < REG_W; k++) begin
            wmask[k] = byte_hit;
            wval[k]  = reg_wdata[k];
            if (bit_hit && (bit_addr[IDX_W-1:0] == IDX_W'(k))) begin
                wmask[k] = 1'b1;
                wval[k]  = bit_val;
            end
        end
    end

    generate
        for (genvar s = 0; s < SRC_N; s++) begin : g_src
            logic     lvl_n, fall;
            src_cfg_t cfg;

            eic_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst   (rst),
                .pin_n (ext_n[s]),
                .lvl_n (lvl_n),
                .fall  (fall)
            );

            eic_slot u_slot (
                .clk     (clk),
                .rst     (rst),
                .wr_mask (wmask[s*CFG_W +: CFG_W]),
                .wr_val  (wval[s*CFG_W +: CFG_W]),
                .fall    (fall),
                .lvl_act (~lvl_n),
                .ack     (ack[s]),
                .cfg     (cfg)
            );

            assign ctrl_q[s*CFG_W +: CFG_W] = cfg;
            assign irq_req[s] = cfg.en & cfg.flag;
            assign irq_hi[s]  = cfg.pri;
        end
    endgenerate

    eic_sel u_sel (
        .req   (irq_req),
        .hi    (irq_hi),
        .grant (grant)
    );

    assign reg_rdata   = (reg_addr == REG_ADDR) ? ctrl_q : '0;
    assign grant_valid = grant.valid;
    assign grant_id    = grant.id;
    assign grant_hi    = grant.hi;

endmodule

// File: rtl/eic_ctrl_chk.sv
module eic_ctrl_chk
    import eic_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] ctrl_q,
    input logic [SRC_N-1:0] ack,
    input logic             reg_wr,
    input logic             bit_wr,
    input logic [SRC_N-1:0] irq_req,
    input logic [SRC_N-1:0] irq_hi,
    input logic             grant_valid,
    input logic [ID_W-1:0]  grant_id
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_q == '0 && irq_req == '0)); // R1

    AST_GRANT_VALID: assert property (@(posedge clk) disable iff (rst)
        grant_valid == (|irq_req)); // R9

    AST_TIE_TO_A: assert property (@(posedge clk) disable iff (rst)
        (irq_req[0] && (irq_hi[0] || !irq_req[1] || !irq_hi[1])) |-> grant_id == '0); // R9

    AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (rst)
        (irq_req[1] && irq_hi[1] && !(irq_req[0] && irq_hi[0])) |-> grant_id == ID_W'(1)); // R9

    generate
        for (genvar s = 0; s < SRC_N; s++) begin : g_chk
            AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
                irq_req[s] |-> (ctrl_q[s*CFG_W+POS_EN] && ctrl_q[s*CFG_W+POS_FLAG])); // R7

            AST_LEVEL_FOLLOWS_PRI: assert property (@(posedge clk) disable iff (rst)
                irq_req[s] |-> (irq_hi[s] == ctrl_q[s*CFG_W+POS_PRI])); // R8

            AST_EDGE_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
                (ctrl_q[s*CFG_W+POS_TYP] && ctrl_q[s*CFG_W+POS_FLAG] && !ack[s] && !reg_wr && !bit_wr)
                |=> ctrl_q[s*CFG_W+POS_FLAG]); // R4
        end
    endgenerate

endmodule

bind eic_ctrl eic_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctrl_q      (ctrl_q),
    .ack         (ack),
    .reg_wr      (reg_wr),
    .bit_wr      (bit_wr),
    .irq_req     (irq_req),
    .irq_hi      (irq_hi),
    .grant_valid (grant_valid),
    .grant_id    (grant_id)
);

// File: tb/eic_ctrl_test.sv
`timescale 1ns/100ps
module eic_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ext_n = 2'b11;
    logic [7:0] reg_addr = 8'hC0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       bit_wr = 1'b0;
    logic [7:0] bit_addr = 8'hC0;
    logic       bit_val = 1'b0;
    logic [1:0] ack = 2'b00;
    logic [1:0] irq_req, irq_hi;
    logic       grant_valid, grant_id, grant_hi;

    always #5 clk = ~clk;

    eic_ctrl uut (
        .clk(clk), .rst(rst), .ext_n(ext_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_wr(bit_wr), .bit_addr(bit_addr), .bit_val(bit_val),
        .ack(ack), .irq_req(irq_req), .irq_hi(irq_hi),
        .grant_valid(grant_valid), .grant_id(grant_id), .grant_hi(grant_hi)
    );

    // Observation kinds
    localparam int K_REG = 0, K_REQ = 1, K_HI = 2, K_GNT = 3;

    typedef struct {
        int         kind;
        string      tag;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    function automatic logic [7:0] observe(input int kind);
        case (kind)
            K_REG:   return reg_rdata;
            K_REQ:   return {6'b0, irq_req};
            K_HI:    return {6'b0, irq_hi};
            default: return {5'b0, grant_valid, grant_id, grant_hi};
        endcase
    endfunction

    // Monitor: pops queued expectations and compares
    always begin
        @(chk_ev);
        #0.2;
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it  = q.pop_front();
            got = observe(it.kind);
            n_chk++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, got, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_v(input int kind, input string tag, input logic [7:0] e);
        item_t it;
        it.kind = kind; it.tag = tag; it.exp = e;
        q.push_back(it);
        -> chk_ev;
        #0.4;
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0; reg_addr = 8'hC0;
    endtask

    task automatic bitw(input int n, input logic v);
        bit_addr = 8'hC0 + 8'(n); bit_val = v; bit_wr = 1'b1;
        tick(1);
        bit_wr = 1'b0;
    endtask

    task automatic ackp(input logic [1:0] m);
        ack = m;
        tick(1);
        ack = 2'b00;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        // R1 reset state
        expect_v(K_REG, "R1 reg", 8'h00);
        expect_v(K_REQ, "R1 req", 8'h00);
        expect_v(K_GNT, "R1 grant", 8'h00);

        // R2 byte write; R6 level-mode flag write ignored (flag A reads pin)
        bwrite(8'hC0, 8'h5A);
        expect_v(K_REG, "R2/R6 byte write", 8'h58);
        bwrite(8'hC1, 8'hFF);
        expect_v(K_REG, "R2 other addr write ignored", 8'h58);
        reg_addr = 8'hC1;
        expect_v(K_REG, "R2 other addr reads zero", 8'h00);
        reg_addr = 8'hC0;

        // R3 bit access
        bitw(2, 1'b1);
        expect_v(K_REG, "R3 bit set", 8'h5C);
        bitw(6, 1'b0);
        expect_v(K_REG, "R3 bit clear", 8'h1C);

        // Both edge mode; A enabled low, B enabled high
        bwrite(8'hC0, 8'hD5);
        ext_n[0] = 1'b0;
        tick(2);
        expect_v(K_REG, "R4 not yet after two edges", 8'hD5);
        tick(1);
        expect_v(K_REG, "R4 edge flag A", 8'hD7);
        expect_v(K_REQ, "R7 req A", 8'h01);
        expect_v(K_HI, "R8 levels", 8'h02);
        expect_v(K_GNT, "R9 grant A low", 8'h04);
        ext_n[0] = 1'b1;
        tick(4);
        expect_v(K_REG, "R4 flag sticky", 8'hD7);

        ext_n[1] = 1'b0;
        tick(3);
        expect_v(K_REG, "R4 edge flag B", 8'hF7);
        expect_v(K_REQ, "R7 req both", 8'h03);
        expect_v(K_GNT, "R9 high wins", 8'h07);

        // R5 acknowledge; R10 no retrigger while held low
        ackp(2'b10);
        expect_v(K_REG, "R5 ack clears B", 8'hD7);
        expect_v(K_REQ, "R5 req after ack", 8'h01);
        tick(4);
        expect_v(K_REG, "R10 held low no reset", 8'hD7);
        ext_n[1] = 1'b1;

        // R9 tie at high level goes to A
        bitw(3, 1'b1);
        expect_v(K_REG, "R3 pri A set", 8'hDF);
        ext_n[1] = 1'b0;
        tick(3);
        expect_v(K_REG, "R4 B again", 8'hFF);
        expect_v(K_GNT, "R9 tie to A", 8'h05);
        ext_n[1] = 1'b1;

        // R7 masking keeps flag
        bitw(2, 1'b0);
        expect_v(K_REG, "R7 flag kept when masked", 8'hFB);
        expect_v(K_REQ, "R7 masked req", 8'h02);
        expect_v(K_GNT, "R9 grant B", 8'h07);
        ackp(2'b11);
        expect_v(K_REG, "R5 ack both", 8'hD9);
        expect_v(K_GNT, "R9 no grant", 8'h00);

        // R5 detection beats simultaneous ack
        ext_n[0] = 1'b0;
        tick(2);
        ackp(2'b01);
        expect_v(K_REG, "R5 set wins over ack", 8'hDB);
        ext_n[0] = 1'b1;
        ackp(2'b01);
        expect_v(K_REG, "R5 ack A", 8'hD9);

        // R6 level mode on A
        bitw(0, 1'b0);
        bitw(2, 1'b1);
        expect_v(K_REG, "R6 level cfg", 8'hDC);
        ext_n[0] = 1'b0;
        tick(1);
        expect_v(K_REG, "R6 one edge not yet", 8'hDC);
        tick(1);
        expect_v(K_REG, "R6 level flag", 8'hDE);
        expect_v(K_REQ, "R6 level req", 8'h01);
        ackp(2'b01);
        expect_v(K_REG, "R6 ack ignored", 8'hDE);
        bwrite(8'hC0, 8'hDC);
        expect_v(K_REG, "R6 write ignored", 8'hDE);
        ext_n[0] = 1'b1;
        tick(2);
        expect_v(K_REG, "R6 level released", 8'hDC);
        expect_v(K_REQ, "R6 req released", 8'h00);

        tick(2);
        done = 1'b1;
        summary();
    end

endmodule